// File: doc/BRIEF.md
# Disk DMA Address and Word Count Registers

This block keeps the state of one disk DMA channel: the memory address of the next word and the number of words transferred so far. The CPU programs the address through the address bus. A write anywhere in the address register window does not use the data bus. It takes the value from CPU address lines 13:1, and address line 14 decides which half of the DMA address receives that value. The count register is written through the data bus. It holds a 14-bit word count, a transfer direction bit and an enable bit. The count is stepped once at load time, so a loaded value of N reads back as N+1.

While the channel is enabled, each completed word transfer moves the address forward by one word and increments the count. When the count rolls over, the channel stops itself and sets a terminal-count flag. The flag stays set until the count register is loaded again. The count readback word sets both unused upper bits to one.

Top module: `dmac_regs`

## Requirements
- R1: After reset the DMA address is 0, the count is 0, enable, direction and terminal count are 0, and the count readback is 0xC000.
- R2: An address-window write with CPU address bit 14 at 1 loads DMA address bits 21:9 from CPU address bits 13:1 and leaves DMA address bits 8:1 unchanged.
- R3: An address-window write with CPU address bit 14 at 0 loads DMA address bits 8:1 from CPU address bits 8:1 and leaves DMA address bits 21:9 unchanged.
- R4: DMA address bit 0 always reads 0.
- R5: A 16-bit count write loads the count with (data[13:0] + 1) mod 2^14, loads direction from data bit 14 and enable from data bit 15, and clears terminal count.
- R6: A count write whose size is not 16 bits leaves count, direction, enable and terminal count unchanged.
- R7: The count readback is {2'b11, count[13:0]} at all times.
- R8: A transfer strobe while enabled advances the DMA address by 2, modulo 2^22, and increments the count.
- R9: A transfer strobe while disabled changes neither the address nor the count.
- R10: An enabled transfer at count 0x3FFF wraps the count to 0, sets terminal count and clears enable. Terminal count then stays set until the next 16-bit count write.
- R11: A CPU write to a register in the same cycle as a transfer strobe takes priority, and the transfer does not step that register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_wr_i | input | 1 | Write strobe for the address register window |
| cpu_addr_i | input | 15 | CPU address lines 14:0 during the address write |
| cnt_wr_i | input | 1 | Write strobe for the count register |
| cnt_size16_i | input | 1 | The count write is a 16-bit access |
| cnt_wdata_i | input | 16 | Data bus value for the count write |
| xfer_i | input | 1 | One word transfer completed |
| dma_addr_o | output | 22 | Current DMA byte address |
| cnt_rdata_o | output | 16 | Count register readback word |
| dma_en_o | output | 1 | Channel enabled |
| dma_dir_o | output | 1 | Transfer direction bit |
| tc_o | output | 1 | Terminal count reached |

## Verification
The bench uses the default parameters: a 22-bit address, an 8-bit low half and a 14-bit count. With these values the bit positions in the requirements apply as written. The wrap case does not need thousands of transfers. Loading 0x3FFE leaves the count one step below rollover, so the terminal-count transition, the self-disable and the persistence of the flag all occur within a few cycles. A pseudo-random phase sets up collisions between address writes, count writes of both sizes and transfer strobes. This phase covers write priority in every combination with the channel enabled and disabled.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned EN_BIT  = 15;
  localparam int unsigned DIR_BIT = 14;

  typedef struct packed {
    logic en;
    logic dir;
  } dmac_ctl_t;
endpackage

// File: rtl/dmac_addr_reg.sv
module dmac_addr_reg #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned LO_W   = 8,
  localparam int unsigned HI_W   = ADDR_W - 1 - LO_W,
  localparam int unsigned SEL_B  = HI_W + 1,
  localparam int unsigned CPU_AW = SEL_B + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  // word address: byte bit 0 is not stored
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_i) begin
      if (cpu_addr_i[SEL_B]) hi_q <= cpu_addr_i[HI_W:1];
      else                   lo_q <= cpu_addr_i[LO_W:1];
    end else if (step_i) begin
      {hi_q, lo_q} <= {hi_q, lo_q} + 1'b1;
    end
  end

  assign addr_o = {hi_q, lo_q, 1'b0};

  p_lo_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cpu_addr_i[SEL_B]) |=> addr_o[LO_W:1] == $past(addr_o[LO_W:1]));
  p_hi_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !cpu_addr_i[SEL_B]) |=> addr_o[ADDR_W-1:LO_W+1] == $past(addr_o[ADDR_W-1:LO_W+1]));
  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_i) |=> addr_o == $past(addr_o) + ADDR_W'(2));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !wr_i) |=> $stable(addr_o));
endmodule

// File: rtl/dmac_cnt_reg.sv
module dmac_cnt_reg
  import dmac_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              xfer_i,
  output logic [CNT_W-1:0]  cnt_o,
  output dmac_ctl_t         ctl_o,
  output logic              tc_o
);
  logic [CNT_W-1:0] cnt_q;
  dmac_ctl_t        ctl_q;
  logic             tc_q;
  logic             step;

  assign step = xfer_i && ctl_q.en && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ctl_q <= '0;
      tc_q  <= 1'b0;
    end else if (wr_i) begin
      // load is pre-incremented
      cnt_q     <= wdata_i[CNT_W-1:0] + 1'b1;
      ctl_q.en  <= wdata_i[EN_BIT];
      ctl_q.dir <= wdata_i[DIR_BIT];
      tc_q      <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) begin
        tc_q     <= 1'b1;
        ctl_q.en <= 1'b0;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ctl_o = ctl_q;
  assign tc_o  = tc_q;

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_o == $past(wdata_i[CNT_W-1:0]) + 1'b1) && !tc_o);
  p_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && xfer_i && ctl_o.en && (&cnt_o)) |=> (tc_o && !ctl_o.en && cnt_o == '0));
  p_tc_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !wr_i) |=> tc_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !ctl_o.en) |=> $stable(cnt_o) && !ctl_o.en);
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned LO_W   = 8,
  parameter int unsigned CNT_W  = 14,
  localparam int unsigned CPU_AW = ADDR_W - LO_W + 1,
  localparam int unsigned PAD_W  = DATA_W - CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic              cnt_wr_i,
  input  logic              cnt_size16_i,
  input  logic [DATA_W-1:0] cnt_wdata_i,
  input  logic              xfer_i,
  output logic [ADDR_W-1:0] dma_addr_o,
  output logic [DATA_W-1:0] cnt_rdata_o,
  output logic              dma_en_o,
  output logic              dma_dir_o,
  output logic              tc_o
);
  logic             cnt_wr;
  logic [CNT_W-1:0] cnt;
  dmac_ctl_t        ctl;

  assign cnt_wr = cnt_wr_i && cnt_size16_i;

  dmac_addr_reg #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (addr_wr_i),
    .cpu_addr_i (cpu_addr_i),
    .step_i     (xfer_i && ctl.en),
    .addr_o     (dma_addr_o)
  );

  dmac_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cnt_wr),
    .wdata_i (cnt_wdata_i),
    .xfer_i  (xfer_i),
    .cnt_o   (cnt),
    .ctl_o   (ctl),
    .tc_o    (tc_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign cnt_rdata_o = {{PAD_W{1'b1}}, cnt};
    end else begin : g_nopad
      assign cnt_rdata_o = cnt;
    end
  endgenerate

  assign dma_en_o  = ctl.en;
  assign dma_dir_o = ctl.dir;

  p_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i && !cnt_size16_i && !(xfer_i && dma_en_o)) |=>
      $stable(cnt_rdata_o) && $stable(dma_en_o) && $stable(dma_dir_o) && $stable(tc_o));
  p_even_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_addr_o[0]);
  p_cpu_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr && xfer_i) |=> cnt_rdata_o[CNT_W-1:0] == $past(cnt_wdata_i[CNT_W-1:0]) + 1'b1);
endmodule

// File: tb/sim_dmac_regs.sv
module sim_dmac_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_wr = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic        cnt_wr = 1'b0;
  logic        cnt_size16 = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        xfer = 1'b0;
  logic [21:0] dma_addr;
  logic [15:0] cnt_rdata;
  logic        dma_en, dma_dir, tc;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  int unsigned m_addr = 0, m_cnt = 0;
  bit m_en = 0, m_dir = 0, m_tc = 0;

  always #4 clk = ~clk;

  dmac_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_wr_i(addr_wr), .cpu_addr_i(cpu_addr),
    .cnt_wr_i(cnt_wr), .cnt_size16_i(cnt_size16), .cnt_wdata_i(cnt_wdata),
    .xfer_i(xfer), .dma_addr_o(dma_addr), .cnt_rdata_o(cnt_rdata),
    .dma_en_o(dma_en), .dma_dir_o(dma_dir), .tc_o(tc)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_addr = 0; m_cnt = 0; m_en = 0; m_dir = 0; m_tc = 0;
    end else begin
      if (addr_wr) begin
        if (cpu_addr[14]) m_addr = (m_addr & 32'h1FE) | ((32'(cpu_addr) & 32'h3FFE) << 8);
        else              m_addr = (m_addr & 32'h3FFE00) | (32'(cpu_addr) & 32'h1FE);
      end else if (xfer && m_en) m_addr = (m_addr + 2) & 32'h3FFFFF;
      if (cnt_wr && cnt_size16) begin
        m_cnt = ((32'(cnt_wdata) & 32'h3FFF) + 1) & 32'h3FFF;
        m_dir = cnt_wdata[14];
        m_en  = cnt_wdata[15];
        m_tc  = 0;
      end else if (xfer && m_en) begin
        if (m_cnt == 32'h3FFF) begin m_cnt = 0; m_tc = 1; m_en = 0; end
        else m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      vectors++;
      if (dma_addr != m_addr[21:0] || dma_addr[0] != 1'b0) begin
        fails++;
        $display("FAIL %s addr: actual %h expected %h", cur_req, dma_addr, m_addr[21:0]);
      end
      if (cnt_rdata != (16'hC000 | m_cnt[15:0])) begin
        fails++;
        $display("FAIL %s/R7 count readback: actual %h expected %h", cur_req, cnt_rdata,
                 16'hC000 | m_cnt[15:0]);
      end
      if ({dma_en, dma_dir, tc} != {m_en, m_dir, m_tc}) begin
        fails++;
        $display("FAIL %s en/dir/tc: actual %b%b%b expected %b%b%b", cur_req,
                 dma_en, dma_dir, tc, m_en, m_dir, m_tc);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      addr_wr = 0; cnt_wr = 0; cnt_size16 = 0; xfer = 0;
    end
  endtask

  task automatic drive(input bit aw, input logic [14:0] a, input bit cw, input bit c16,
                       input logic [15:0] d, input bit x);
    @(negedge clk);
    #1;
    addr_wr = aw; cpu_addr = a; cnt_wr = cw; cnt_size16 = c16; cnt_wdata = d; xfer = x;
  endtask

  initial begin
    int unsigned lfsr;
    lfsr = 32'hACE1;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    cur_req = "R1"; idle(3);
    cur_req = "R3"; drive(1, 15'h01FE, 0, 0, 0, 0); idle(2);
    cur_req = "R2"; drive(1, 15'h4000 | 15'h2AAA, 0, 0, 0, 0); idle(2);
    cur_req = "R3"; drive(1, 15'h3E54, 0, 0, 0, 0); idle(2);
    cur_req = "R6"; drive(0, 0, 1, 0, 16'hC005, 0); idle(2);
    cur_req = "R5"; drive(0, 0, 1, 1, 16'hC00A, 0); idle(2);
    cur_req = "R8"; for (int i = 0; i < 5; i++) drive(0, 0, 0, 0, 0, 1); idle(2);
    cur_req = "R11"; drive(1, 15'h4002, 1, 1, 16'h8100, 1); idle(2);
    cur_req = "R4"; drive(1, 15'h01FF, 0, 0, 0, 1); idle(2);
    cur_req = "R9"; drive(0, 0, 1, 1, 16'h0003, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 0, 1); idle(2);
    cur_req = "R10"; drive(0, 0, 1, 1, 16'hBFFE, 0);
    drive(0, 0, 0, 0, 0, 1); drive(0, 0, 0, 0, 0, 1); drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 1, 0, 16'h8000, 1); idle(3);
    drive(0, 0, 1, 1, 16'h8000, 0); idle(2);
    cur_req = "R6"; drive(0, 0, 1, 0, 16'h0000, 0); idle(2);
    cur_req = "R11";
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      drive(lfsr[20:18] == 0, lfsr[14:0], lfsr[23:21] == 0, lfsr[24],
            {lfsr[25], lfsr[26], lfsr[13:0] | {14{lfsr[27]}}}, lfsr[28] | lfsr[29]);
    end
    idle(3);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule